// File: doc/BRIEF.md
# Configurable FP32 Adder Slice

This block is a pipelined single-precision floating-point adder with a selectable source for each of its two operands. Each operand can be constant zero, the `c_in` port, the `d_in` port, the `casc_in` port from a neighbouring slice, or the slice's own registered sum fed back. A per-operand control flips the sign of the chosen value, so one slice can add, subtract, negate, or keep a running total.

The result always appears on `sum_out`. It can also be placed on `casc_out`, which feeds the `casc_in` of the next slice, so a row of slices sums many terms. Rounding is round-to-nearest-even. Subnormals are treated as zero. Exception flags are not produced. A NaN result is always the single quiet pattern `32'h7FC00000`.

All data and control inputs are captured together at a rising edge. After that, the adder has a fixed latency of two more edges, and it accepts a new operation on every clock.

Top module: `fp32_add_slice`

## Requirements
- R1: Inputs are sampled at a rising edge. The sum built from those samples appears on `sum_out` after the second rising edge that follows. A new operation is accepted on every clock.
- R2: Each 3-bit operand select uses this encoding: 0 gives +0, 1 gives `c_in`, 2 gives `d_in`, 3 gives `casc_in`, 4 gives the current `sum_out`. Codes 5 to 7 give +0. The encoding is the same for both operands.
- R3: When `x_neg` (or `y_neg`) is 1, bit 31 of the selected x (or y) operand is inverted before the addition.
- R4: The feedback source reads `sum_out` in the cycle after capture. A term captured at edge k is therefore added to the result of the operation captured at edge k-2. Continuous feedback keeps two interleaved partial sums.
- R5: `casc_en` is captured with the data. `casc_out` equals `sum_out` for that operation when `casc_en` was 1, and is all zeros when it was 0.
- R6: Finite results are rounded to nearest, with ties to even.
- R7: An input with exponent field 0 counts as a zero of its own sign. A result whose biased exponent after rounding would be below 1 becomes a zero with the result's sign. `sum_out` never holds a subnormal.
- R8: An exact zero result is +0, except when both operands are negative zeros, which gives -0.
- R9: A result whose biased exponent after rounding would be 255 or more becomes an infinity with the result's sign.
- R10: A NaN operand, or two infinities of opposite sign, gives `32'h7FC00000`. One infinity plus a finite value gives that infinity.
- R11: A synchronous reset sets `sum_out`, `casc_out` and every pipeline register to +0, and resets the captured selects to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| c_in | input | 32 | First external data operand |
| d_in | input | 32 | Second external data operand |
| casc_in | input | 32 | Sum arriving from the previous slice |
| x_sel | input | 3 | Source code for operand x |
| y_sel | input | 3 | Source code for operand y |
| x_neg | input | 1 | Invert the sign of operand x |
| y_neg | input | 1 | Invert the sign of operand y |
| casc_en | input | 1 | Drive this operation's result onto `casc_out` |
| sum_out | output | 32 | Registered sum |
| casc_out | output | 32 | Registered sum for the next slice, or zero |

## Verification
The hardest state to reach from the ports is the feedback path while other operations are still in flight. The value fed back depends on which operation sits two stages ahead, so isolated vectors cannot exercise it. The bench therefore runs a cycle-accurate model of the capture, align and round registers. It sweeps every pair of operand selects with every pair of sign inversions back to back, so feedback always lands on an earlier, unrelated result. Rounding, flush-to-zero and overflow cases come from a deterministic pseudo-random operand stream with narrowed exponent ranges. Subnormals, signed zeros, infinities and NaNs are placed directly.

// File: rtl/fp32_slice_pkg.sv
package fp32_slice_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EXT_W  = MANT_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int LZ_W   = $clog2(EXT_W);
  localparam int SEL_W  = 3;
  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO = 3'd0,
    SRC_C    = 3'd1,
    SRC_D    = 3'd2,
    SRC_CASC = 3'd3,
    SRC_FB   = 3'd4
  } src_e;

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] special_val;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SUM_W-1:0]  mag;
    logic              zero_sign;
  } stage1_t;

  function automatic logic fp_is_nan(logic [WORD_W-1:0] v);
    return (v[WORD_W-2 -: EXP_W] == EXP_MAX) && (v[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic fp_is_inf(logic [WORD_W-1:0] v);
    return (v[WORD_W-2 -: EXP_W] == EXP_MAX) && (v[FRAC_W-1:0] == '0);
  endfunction

  // magnitude with subnormals flushed to zero
  function automatic logic [WORD_W-2:0] fp_mag(logic [WORD_W-1:0] v);
    if (v[WORD_W-2 -: EXP_W] == '0) return '0;
    return v[WORD_W-2:0];
  endfunction

  function automatic logic [LZ_W-1:0] fp_lzc(logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (v[i]) n = LZ_W'(EXT_W - 1 - i);
    end
    return n;
  endfunction
endpackage

// File: rtl/fp32_operand_sel.sv
module fp32_operand_sel
  import fp32_slice_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic              neg,
  input  logic [WORD_W-1:0] c_val,
  input  logic [WORD_W-1:0] d_val,
  input  logic [WORD_W-1:0] casc_val,
  input  logic [WORD_W-1:0] fb_val,
  output logic [WORD_W-1:0] opnd
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    case (sel)
      SRC_C:    raw = c_val;
      SRC_D:    raw = d_val;
      SRC_CASC: raw = casc_val;
      SRC_FB:   raw = fb_val;
      default:  raw = '0;
    endcase
    opnd = {raw[WORD_W-1] ^ neg, raw[WORD_W-2:0]};
  end
endmodule

// File: rtl/fp32_align_add.sv
module fp32_align_add
  import fp32_slice_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output stage1_t           s1
);
  logic [WORD_W-2:0] mag_a, mag_b;
  logic              sa, sb, swap;
  logic              big_s, small_s;
  logic [EXP_W-1:0]  big_e, small_e, dexp;
  logic [MANT_W-1:0] big_m, small_m;
  logic [EXT_W-1:0]  big_x, small_x, shifted, lost_mask, aligned;
  logic              sticky;

  always_comb begin
    sa    = opa[WORD_W-1];
    sb    = opb[WORD_W-1];
    mag_a = fp_mag(opa);
    mag_b = fp_mag(opb);
    swap  = mag_b > mag_a;

    big_s   = swap ? sb : sa;
    small_s = swap ? sa : sb;
    big_e   = swap ? mag_b[WORD_W-2 -: EXP_W] : mag_a[WORD_W-2 -: EXP_W];
    small_e = swap ? mag_a[WORD_W-2 -: EXP_W] : mag_b[WORD_W-2 -: EXP_W];
    big_m   = (big_e == '0)   ? '0 : {1'b1, (swap ? mag_b[FRAC_W-1:0] : mag_a[FRAC_W-1:0])};
    small_m = (small_e == '0) ? '0 : {1'b1, (swap ? mag_a[FRAC_W-1:0] : mag_b[FRAC_W-1:0])};
    dexp    = big_e - small_e;

    big_x   = {big_m, 3'b000};
    small_x = {small_m, 3'b000};
    if (dexp >= EXP_W'(EXT_W)) begin
      shifted   = '0;
      lost_mask = '1;
    end else begin
      shifted   = small_x >> dexp;
      lost_mask = ~({EXT_W{1'b1}} << dexp);
    end
    sticky  = |(small_x & lost_mask);
    aligned = {shifted[EXT_W-1:1], shifted[0] | sticky};

    s1.sign      = big_s;
    s1.exp       = big_e;
    s1.zero_sign = sa & sb;
    if (big_s ^ small_s) s1.mag = {1'b0, big_x} - {1'b0, aligned};
    else                 s1.mag = {1'b0, big_x} + {1'b0, aligned};

    s1.special     = 1'b0;
    s1.special_val = '0;
    if (fp_is_nan(opa) || fp_is_nan(opb) ||
        (fp_is_inf(opa) && fp_is_inf(opb) && (sa != sb))) begin
      s1.special     = 1'b1;
      s1.special_val = QNAN;
    end else if (fp_is_inf(opa)) begin
      s1.special     = 1'b1;
      s1.special_val = {sa, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (fp_is_inf(opb)) begin
      s1.special     = 1'b1;
      s1.special_val = {sb, EXP_MAX, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fp32_norm_round.sv
module fp32_norm_round
  import fp32_slice_pkg::*;
(
  input  stage1_t           s1,
  output logic [WORD_W-1:0] res
);
  logic [LZ_W-1:0]        lz;
  logic [EXT_W-1:0]       norm_m;
  logic signed [EXP_W+1:0] e_norm, e_fin;
  logic                   round_up;
  logic [MANT_W:0]        rounded;
  logic [FRAC_W-1:0]      frac;

  always_comb begin
    lz = '0;
    if (s1.mag[SUM_W-1]) begin
      norm_m = {s1.mag[SUM_W-1:2], s1.mag[1] | s1.mag[0]};
      e_norm = $signed({2'b00, s1.exp}) + 10'sd1;
    end else begin
      lz     = fp_lzc(s1.mag[EXT_W-1:0]);
      norm_m = s1.mag[EXT_W-1:0] << lz;
      e_norm = $signed({2'b00, s1.exp}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lz});
    end

    // guard at bit 2, round at bit 1, sticky at bit 0, result lsb at bit 3
    round_up = norm_m[2] & (norm_m[1] | norm_m[0] | norm_m[3]);
    rounded  = {1'b0, norm_m[EXT_W-1:3]} + {{MANT_W{1'b0}}, round_up};
    e_fin    = rounded[MANT_W] ? e_norm + 10'sd1 : e_norm;
    frac     = rounded[MANT_W] ? '0 : rounded[FRAC_W-1:0];

    if (s1.special)
      res = s1.special_val;
    else if (s1.mag == '0)
      res = {s1.zero_sign, {(WORD_W-1){1'b0}}};
    else if (e_fin >= $signed({2'b00, EXP_MAX}))
      res = {s1.sign, EXP_MAX, {FRAC_W{1'b0}}};
    else if (e_fin <= 10'sd0)
      res = {s1.sign, {(WORD_W-1){1'b0}}};
    else
      res = {s1.sign, e_fin[EXP_W-1:0], frac};
  end

  always_comb begin
    if (!s1.special && s1.mag != '0) begin
      norm_hidden_chk: assert (rounded[MANT_W] || rounded[MANT_W-1])
        else $error("normalised mantissa lost its leading one");
    end
  end
endmodule

// File: rtl/fp32_add_slice.sv
module fp32_add_slice
  import fp32_slice_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] c_in,
  input  logic [31:0] d_in,
  input  logic [31:0] casc_in,
  input  logic [2:0]  x_sel,
  input  logic [2:0]  y_sel,
  input  logic        x_neg,
  input  logic        y_neg,
  input  logic        casc_en,
  output logic [31:0] sum_out,
  output logic [31:0] casc_out
);
  localparam int NOPND = 2;

  // capture stage
  logic [WORD_W-1:0]            c_q, d_q, casc_q;
  logic [NOPND-1:0][SEL_W-1:0]  sel_q;
  logic [NOPND-1:0]             neg_q;
  logic                         ce0_q, ce1_q;
  // operand and pipeline wires brought out for the assertions
  logic [NOPND-1:0][WORD_W-1:0] opnd;
  stage1_t                      s1_d, s1_q;
  logic [WORD_W-1:0]            res_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q      <= '0;
      d_q      <= '0;
      casc_q   <= '0;
      sel_q    <= '0;
      neg_q    <= '0;
      ce0_q    <= 1'b0;
      ce1_q    <= 1'b0;
      s1_q     <= '0;
      sum_out  <= '0;
      casc_out <= '0;
    end else begin
      c_q      <= c_in;
      d_q      <= d_in;
      casc_q   <= casc_in;
      sel_q    <= {y_sel, x_sel};
      neg_q    <= {y_neg, x_neg};
      ce0_q    <= casc_en;
      ce1_q    <= ce0_q;
      s1_q     <= s1_d;
      sum_out  <= res_d;
      casc_out <= ce1_q ? res_d : '0;
    end
  end

  for (genvar gi = 0; gi < NOPND; gi++) begin : g_opnd
    fp32_operand_sel u_sel (
      .sel      (sel_q[gi]),
      .neg      (neg_q[gi]),
      .c_val    (c_q),
      .d_val    (d_q),
      .casc_val (casc_q),
      .fb_val   (sum_out),
      .opnd     (opnd[gi])
    );
  end

  fp32_align_add u_align (
    .opa (opnd[0]),
    .opb (opnd[1]),
    .s1  (s1_d)
  );

  fp32_norm_round u_round (
    .s1  (s1_q),
    .res (res_d)
  );

  // R1 R2
  zero_src_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0 && neg_q == '0) |=> ##1 (sum_out == '0))
    else $error("two zero operands did not give +0 two edges later");

  // R5
  casc_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (casc_out != '0) |-> (casc_out == sum_out))
    else $error("cascade output differs from the sum");

  // R7
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    (sum_out[30:23] == '0) |-> (sum_out[22:0] == '0))
    else $error("subnormal value on sum_out");

  // R10
  nan_canon_chk: assert property (@(posedge clk) disable iff (rst)
    (sum_out[30:23] == EXP_MAX && sum_out[22:0] != '0) |-> (sum_out == QNAN))
    else $error("non-canonical NaN on sum_out");

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum_out == '0 && casc_out == '0))
    else $error("outputs not cleared by reset");
endmodule

// File: tb/fp32_add_slice_tb.sv
`timescale 1ns/1ps
module fp32_add_slice_tb;
  localparam logic [31:0] QN = 32'h7FC00000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] c_in = '0, d_in = '0, casc_in = '0;
  logic [2:0]  x_sel = '0, y_sel = '0;
  logic        x_neg = 1'b0, y_neg = 1'b0, casc_en = 1'b0;
  logic [31:0] sum_out, casc_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // model registers
  logic [31:0] m_c, m_d, m_k, m_s1, m_res;
  logic [2:0]  m_xs, m_ys;
  logic        m_xn, m_yn, m_ce0, m_ce1, m_ce2;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  fp32_add_slice u_dut (
    .clk(clk), .rst(rst), .c_in(c_in), .d_in(d_in), .casc_in(casc_in),
    .x_sel(x_sel), .y_sel(y_sel), .x_neg(x_neg), .y_neg(y_neg),
    .casc_en(casc_en), .sum_out(sum_out), .casc_out(casc_out)
  );

  // exact-integer reference adder
  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b);
    int ea, eb, ehi, elo, k, p, sh, e;
    longint mhi, mlo, s;
    logic [63:0] u, q, rem, half;
    logic sa, sb, sg;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    sa = a[31]; sb = b[31];
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return QN;
    if (ea == 255 && eb == 255) return (sa == sb) ? a : QN;
    if (ea == 255) return a;
    if (eb == 255) return b;
    if (ea == 0 && eb == 0) return {sa & sb, 31'b0};
    if (ea == 0) return b;
    if (eb == 0) return a;
    if (ea >= eb) begin
      ehi = ea; elo = eb;
      mhi = longint'({1'b1, a[22:0]}); mlo = longint'({1'b1, b[22:0]});
      if (sa) mhi = -mhi;
      if (sb) mlo = -mlo;
    end else begin
      ehi = eb; elo = ea;
      mhi = longint'({1'b1, b[22:0]}); mlo = longint'({1'b1, a[22:0]});
      if (sb) mhi = -mhi;
      if (sa) mlo = -mlo;
    end
    k = ehi - elo;
    if (k > 34) begin
      k = 34;
      mlo = (mlo < 0) ? -64'sd1 : 64'sd1;
    end
    s = (mhi <<< k) + mlo;
    if (s == 0) return 32'h0;
    sg = (s < 0);
    u = sg ? 64'(-s) : 64'(s);
    p = -1;
    for (int i = 63; i >= 0; i--) if (u[i] && p < 0) p = i;
    if (p > 23) begin
      sh = p - 23;
      q = u >> sh;
      rem = u - (q << sh);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == 64'd1 << 24) begin q = q >> 1; sh = sh + 1; end
    end else begin
      sh = p - 23;
      q = u << (23 - p);
    end
    e = ehi - k + sh;
    if (e >= 255) return {sg, 8'hFF, 23'b0};
    if (e <= 0) return {sg, 31'b0};
    return {sg, e[7:0], q[22:0]};
  endfunction

  function automatic logic [31:0] pick(logic [2:0] s, logic n, logic [31:0] c,
                                       logic [31:0] d, logic [31:0] k, logic [31:0] f);
    logic [31:0] v;
    v = (s == 3'd1) ? c : (s == 3'd2) ? d : (s == 3'd3) ? k : (s == 3'd4) ? f : 32'h0;
    return {v[31] ^ n, v[30:0]};
  endfunction

  task automatic model_clear();
    m_c = 0; m_d = 0; m_k = 0; m_s1 = 0; m_res = 0;
    m_xs = 0; m_ys = 0; m_xn = 0; m_yn = 0;
    m_ce0 = 0; m_ce1 = 0; m_ce2 = 0;
  endtask

  // one clock: drive, clock, advance the model, compare
  task automatic step(input logic [31:0] c, input logic [31:0] d, input logic [31:0] k,
                      input logic [2:0] xs, input logic [2:0] ys, input logic xn,
                      input logic yn, input logic ce, input string tag);
    logic [31:0] nxt_s1, exp_c;
    @(negedge clk);
    c_in = c; d_in = d; casc_in = k; x_sel = xs; y_sel = ys;
    x_neg = xn; y_neg = yn; casc_en = ce;
    @(posedge clk);
    #1;
    if (rst) model_clear();
    else begin
      nxt_s1 = ref_add(pick(m_xs, m_xn, m_c, m_d, m_k, m_res),
                       pick(m_ys, m_yn, m_c, m_d, m_k, m_res));
      m_res = m_s1; m_ce2 = m_ce1;
      m_s1 = nxt_s1; m_ce1 = m_ce0;
      m_c = c; m_d = d; m_k = k; m_xs = xs; m_ys = ys;
      m_xn = xn; m_yn = yn; m_ce0 = ce;
    end
    exp_c = m_ce2 ? m_res : 32'h0;
    n_vec++;
    if (sum_out !== m_res || casc_out !== exp_c) begin
      n_bad++;
      $display("FAIL %s sum_out=%h exp=%h casc_out=%h exp=%h", tag, sum_out, m_res, casc_out, exp_c);
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic logic [31:0] rnd_fp(logic [31:0] r, int elo, int span);
    int e;
    e = elo + int'(r[30:23]) % span;
    return {r[31], e[7:0], r[22:0] ^ {r[7:0], r[15:1]}};
  endfunction

  task automatic next_seed();
    seed = seed * 32'd1664525 + 32'd1013904223;
  endtask

  initial begin
    logic [31:0] a, b;
    model_clear();
    // R11: reset state
    rst = 1'b1;
    step(32'h3F800000, 32'h40000000, 0, 1, 2, 0, 0, 1, "R11 reset hold");
    step(32'h3F800000, 32'h40000000, 0, 1, 2, 0, 0, 1, "R11 reset hold");
    rst = 1'b0;
    // R1: single operation then zeros
    step(32'h3FC00000, 32'h40100000, 0, 1, 2, 0, 0, 0, "R1 latency");
    flush("R1 latency");
    // R2 R3 R4 R5: every select and sign pair, back to back
    for (int xs = 0; xs < 8; xs++)
      for (int ys = 0; ys < 8; ys++)
        for (int nn = 0; nn < 4; nn++)
          step(32'h3FC00000, 32'hC0100000, 32'h40490FDB, xs[2:0], ys[2:0],
               nn[0], nn[1], (xs + ys + nn) % 2 == 0, "R2 R3 R4 R5 select sweep");
    flush("R2 select sweep");
    // R4: accumulator, two interleaved partial sums
    for (int i = 0; i < 24; i++)
      step(32'h3F800000 + i * 32'h10000, 0, 0, 3'd4, 3'd1, 0, 0, 1, "R4 accumulate");
    for (int i = 0; i < 12; i++)
      step(0, 0, 0, 3'd4, 3'd0, 0, 0, 1, "R4 accumulate hold");
    flush("R4 accumulate");
    // R6: rounding over close exponents, add and subtract
    for (int i = 0; i < 3000; i++) begin
      next_seed(); a = rnd_fp(seed, 110, 40);
      next_seed(); b = rnd_fp(seed, 110, 40);
      step(a, b, 0, 3'd1, 3'd2, 0, i[0], i[1], "R6 rounding");
    end
    // R6: wide exponent gaps
    for (int i = 0; i < 1000; i++) begin
      next_seed(); a = rnd_fp(seed, 1, 254);
      next_seed(); b = rnd_fp(seed, 1, 254);
      step(a, 0, b, 3'd1, 3'd3, 0, i[0], 1, "R6 wide gap");
    end
    // R7: near-underflow results and subnormal inputs
    for (int i = 0; i < 1000; i++) begin
      next_seed(); a = rnd_fp(seed, 1, 3);
      next_seed(); b = rnd_fp(seed, 1, 3);
      step(a, b, 0, 3'd1, 3'd2, 0, 1, 0, "R7 underflow");
    end
    step(32'h00400000, 32'h3F800000, 0, 1, 2, 0, 0, 0, "R7 subnormal in");
    step(32'h80000001, 32'h00000000, 0, 1, 2, 0, 0, 0, "R7 subnormal pair");
    step(32'h00800001, 32'h00800000, 0, 1, 2, 0, 1, 0, "R7 flush");
    // R8: signed zeros
    for (int i = 0; i < 4; i++)
      step({i[0], 31'b0}, {i[1], 31'b0}, 0, 1, 2, 0, 0, 0, "R8 zero sign");
    step(32'h3F800000, 32'h3F800000, 0, 1, 2, 0, 1, 0, "R8 cancel");
    step(32'hBF800000, 32'h3F800000, 0, 1, 2, 0, 0, 0, "R8 cancel");
    // R9: overflow
    step(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 1, 2, 0, 0, 1, "R9 overflow");
    step(32'hFF7FFFFF, 32'h7F7FFFFF, 0, 1, 2, 0, 1, 1, "R9 overflow neg");
    step(32'h7F7FFFFF, 32'h73000000, 0, 1, 2, 0, 0, 1, "R9 round to inf");
    // R10: specials
    step(32'h7F800000, 32'hFF800000, 0, 1, 2, 0, 0, 0, "R10 inf minus inf");
    step(32'h7F800000, 32'h7F800000, 0, 1, 2, 0, 1, 0, "R10 inf minus inf neg");
    step(32'h7F800000, 32'h3F800000, 0, 1, 2, 1, 0, 0, "R10 inf plus finite");
    step(32'h7FA00001, 32'h3F800000, 0, 1, 2, 0, 0, 0, "R10 nan");
    step(32'h3F800000, 32'hFFFFFFFF, 0, 1, 2, 0, 0, 0, "R10 nan");
    step(32'h00000000, 32'hFF800000, 0, 1, 2, 0, 0, 0, "R10 inf plus zero");
    flush("R10 specials");
    // R11: reset in mid flight
    step(32'h40000000, 32'h40400000, 0, 1, 2, 0, 0, 1, "R11 mid");
    step(32'h40000000, 32'h40400000, 0, 4, 1, 0, 0, 1, "R11 mid");
    rst = 1'b1;
    step(32'h40000000, 32'h40400000, 0, 4, 1, 0, 0, 1, "R11 mid reset");
    rst = 1'b0;
    step(0, 0, 0, 4, 0, 0, 0, 1, "R11 after reset");
    flush("R11 after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got=%0d vectors exp=completion", n_vec);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule